// File: doc/BRIEF.md
# PHY Register Access Handshake Master

This block gives on-chip logic read and write access to the 16-bit internal registers of a serial PHY that are not memory mapped. The PHY exposes one 32-bit control word, which this block drives, and one 32-bit status word, which it samples. Every transfer is a chain of four-phase request/acknowledge exchanges. The block raises a request bit and waits for the acknowledge to go high. It then drops the request and waits for the acknowledge to go low.

A user issues a command while `ready` is high. The command is read or write, with a 16-bit register address and, for a write, 16-bit data. The block first latches the address into the PHY. A read then pulses the read strobe and captures the returned 16 bits. A write latches the data and then pulses the write strobe. Each acknowledge wait checks the status word up to a set number of times, with a programmable number of clock cycles between checks. If a wait never sees the level it needs, the transfer is abandoned, the control word goes back to zero and an error pulse replaces the done pulse.

Top module: `phy_ctl_master`

## Requirements
- R1: After synchronous reset the block has `ready`=1, `done`=0, `timeout_err`=0 and `phy_ctrl`=0.
- R2: Control word layout: bits 15:0 carry the address or data, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. The status word has the acknowledge at bit 16 and read data at bits 15:0.
- R3: Every command starts with an address phase. The control word goes to the address alone, then to the address with capture-address set. After the acknowledge rises it returns to the address alone, and the block waits for the acknowledge to fall.
- R4: A read then drives the read strobe alone and waits for the acknowledge to rise. It captures status bits 15:0 into `rdata`, drives the control word to zero and waits for the acknowledge to fall.
- R5: A write then drives the data alone, then the data with capture-data set, and waits for the acknowledge to rise. It returns to the data alone and waits for the fall. It then drives the write strobe alone and waits for the rise, returns to the data alone and waits for the fall, and ends with the control word at zero.
- R6: Each acknowledge wait samples at most MAX_POLLS times, SAMPLE_DIV clock cycles apart. If the expected level is not seen, the transfer ends with a one-cycle `timeout_err`, `phy_ctrl` at zero and `ready` high.
- R7: A command is accepted only while `ready` is high. `cmd_valid` during a transfer is ignored.
- R8: `done` and `timeout_err` are one-cycle pulses that never occur together. Each one coincides with `ready` returning high.
- R9: At most one of the four request bits (16 to 19) of the control word is set at any time, and the control word is zero whenever `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken while ready is high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Data for a write |
| ready | output | 1 | Idle, a command can be accepted |
| rdata | output | 16 | Data returned by the last successful read |
| done | output | 1 | One-cycle pulse: transfer completed |
| timeout_err | output | 1 | One-cycle pulse: an acknowledge wait expired |
| phy_ctrl | output | 32 | Control word to the PHY |
| phy_stat | input | 32 | Status word from the PHY |

## Verification
A wrong sequencer step shows up at once in the `phy_ctrl` sequence. A skipped, repeated or misordered word is visible in the cycle after the faulty transition, so the bench logs every change of the control word and compares the whole sequence with one it builds from the command. A wrong poll count or spacing shifts the `timeout_err` pulse by at least SAMPLE_DIV cycles. The bench measures the cycles from command acceptance to that pulse, and checks acknowledge delays just inside and just outside the window. A wrong capture instant or address latch shows in `rdata` when written values are read back.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  // Control word field positions (R2)
  localparam int unsigned FLD_W      = 16;
  localparam int unsigned BIT_CAP_A  = 16;
  localparam int unsigned BIT_CAP_D  = 17;
  localparam int unsigned BIT_WR     = 18;
  localparam int unsigned BIT_RD     = 19;
  // Status word field positions (R2)
  localparam int unsigned BIT_ACK    = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_SET,
    ST_ADR_CAP,
    ST_ADR_REL,
    ST_RD_STB,
    ST_RD_CLR,
    ST_WD_SET,
    ST_WD_CAP,
    ST_WD_REL,
    ST_WR_STB,
    ST_WR_REL
  } step_t;
endpackage

// File: rtl/phy_ack_poller.sv
module phy_ack_poller #(
  parameter int unsigned SAMPLE_DIV = 100,
  parameter int unsigned MAX_POLLS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic expect_lvl,
  input  logic ack_in,
  output logic poll_ok,
  output logic poll_fail
);
  localparam int unsigned CW = $clog2(MAX_POLLS + 1);
  localparam int unsigned TW = $clog2(SAMPLE_DIV + 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(MAX_POLLS - 1);
  localparam logic [TW-1:0] GAP       = TW'(SAMPLE_DIV - 1);

  logic          busy;
  logic          want;
  logic [CW-1:0] polls;
  logic [TW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      want      <= 1'b0;
      polls     <= '0;
      gap_cnt   <= '0;
      poll_ok   <= 1'b0;
      poll_fail <= 1'b0;
    end else begin
      poll_ok   <= 1'b0;
      poll_fail <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        want    <= expect_lvl;
        polls   <= '0;
        gap_cnt <= '0;
      end else if (busy) begin
        if (gap_cnt != '0) begin
          gap_cnt <= gap_cnt - 1'b1;
        end else if (ack_in == want) begin
          busy    <= 1'b0;
          poll_ok <= 1'b1;
        end else if (polls == LAST_POLL) begin
          busy      <= 1'b0;
          poll_fail <= 1'b1;
        end else begin
          polls   <= polls + 1'b1;
          gap_cnt <= GAP;
        end
      end
    end
  end

  // R6: the poll counter never passes the sample budget
  p_poll_budget_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (polls <= LAST_POLL));
  // R6: a wait ends in exactly one way
  p_ok_fail_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(poll_ok && poll_fail));
  // R6: the spacing counter stays inside one sample interval
  p_gap_bound_r6: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= GAP);
endmodule

// File: rtl/phy_seq.sv
module phy_seq
  import phy_ctl_pkg::*;
#(
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              ack_in,
  input  logic [DATA_W-1:0] stat_data,
  input  logic              poll_ok,
  input  logic              poll_fail,
  output logic              poll_start,
  output logic              poll_lvl,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              timeout_err,
  output logic [CTRL_W-1:0] ctrl
);
  localparam logic [CTRL_W-1:0] M_CAP_A = CTRL_W'(1) << BIT_CAP_A;
  localparam logic [CTRL_W-1:0] M_CAP_D = CTRL_W'(1) << BIT_CAP_D;
  localparam logic [CTRL_W-1:0] M_WR    = CTRL_W'(1) << BIT_WR;
  localparam logic [CTRL_W-1:0] M_RD    = CTRL_W'(1) << BIT_RD;

  step_t             step;
  logic              is_wr;
  logic [DATA_W-1:0] adr_q;
  logic [DATA_W-1:0] dat_q;
  logic [CTRL_W-1:0] adr_w;
  logic [CTRL_W-1:0] dat_w;
  logic              waiting;

  assign adr_w = CTRL_W'(adr_q);
  assign dat_w = CTRL_W'(dat_q);

  always_comb begin
    case (step)
      ST_ADR_CAP, ST_ADR_REL, ST_RD_STB, ST_RD_CLR,
      ST_WD_CAP, ST_WD_REL, ST_WR_STB, ST_WR_REL: waiting = 1'b1;
      default:                                     waiting = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step        <= ST_IDLE;
      is_wr       <= 1'b0;
      adr_q       <= '0;
      dat_q       <= '0;
      ready       <= 1'b1;
      rdata       <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      ctrl        <= '0;
      poll_start  <= 1'b0;
      poll_lvl    <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      poll_start  <= 1'b0;
      if (waiting && poll_fail) begin
        ctrl        <= '0;
        timeout_err <= 1'b1;
        ready       <= 1'b1;
        step        <= ST_IDLE;
      end else begin
        case (step)
          ST_IDLE: if (cmd_valid) begin
            is_wr <= cmd_write;
            adr_q <= cmd_addr;
            dat_q <= cmd_wdata;
            ctrl  <= CTRL_W'(cmd_addr);
            ready <= 1'b0;
            step  <= ST_ADR_SET;
          end
          ST_ADR_SET: begin
            ctrl       <= adr_w | M_CAP_A;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b1;
            step       <= ST_ADR_CAP;
          end
          ST_ADR_CAP: if (poll_ok) begin
            ctrl       <= adr_w;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b0;
            step       <= ST_ADR_REL;
          end
          ST_ADR_REL: if (poll_ok) begin
            if (is_wr) begin
              ctrl <= dat_w;
              step <= ST_WD_SET;
            end else begin
              ctrl       <= M_RD;
              poll_start <= 1'b1;
              poll_lvl   <= 1'b1;
              step       <= ST_RD_STB;
            end
          end
          ST_RD_STB: if (poll_ok) begin
            rdata      <= stat_data;
            ctrl       <= '0;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b0;
            step       <= ST_RD_CLR;
          end
          ST_RD_CLR: if (poll_ok) begin
            done  <= 1'b1;
            ready <= 1'b1;
            step  <= ST_IDLE;
          end
          ST_WD_SET: begin
            ctrl       <= dat_w | M_CAP_D;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b1;
            step       <= ST_WD_CAP;
          end
          ST_WD_CAP: if (poll_ok) begin
            ctrl       <= dat_w;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b0;
            step       <= ST_WD_REL;
          end
          ST_WD_REL: if (poll_ok) begin
            ctrl       <= M_WR;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b1;
            step       <= ST_WR_STB;
          end
          ST_WR_STB: if (poll_ok) begin
            ctrl       <= dat_w;
            poll_start <= 1'b1;
            poll_lvl   <= 1'b0;
            step       <= ST_WR_REL;
          end
          ST_WR_REL: if (poll_ok) begin
            ctrl  <= '0;
            done  <= 1'b1;
            ready <= 1'b1;
            step  <= ST_IDLE;
          end
          default: step <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: one request bit at most
  p_one_request_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl[BIT_RD:BIT_CAP_A]));
  // R9: idle leaves the control word cleared
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ctrl == '0));
  // R8: completion and error never coincide
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout_err));
  // R8: pulses last one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);
  // R8: either ending returns the block to idle
  p_end_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (done || timeout_err) |-> ready);
  // R7: a busy block keeps its latched address
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$past(ready)) |-> $stable(adr_q));
  // R4: read data only moves at the read-strobe acknowledge
  p_rdata_move_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> ($past(step) == ST_RD_STB));
  // R3: the address phase only moves on after an acknowledge
  p_adr_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (step == ST_ADR_CAP && !poll_ok && !poll_fail) |=> (step == ST_ADR_CAP));
  // R5: the write strobe is only raised after the data release
  p_wr_order_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl[BIT_WR]) |-> ($past(step) == ST_WD_REL));
endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master #(
  parameter int unsigned SAMPLE_DIV = 100,
  parameter int unsigned MAX_POLLS  = 10,
  parameter int unsigned CTRL_W     = 32,
  parameter int unsigned DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              timeout_err,
  output logic [CTRL_W-1:0] phy_ctrl,
  input  logic [CTRL_W-1:0] phy_stat
);
  import phy_ctl_pkg::*;

  logic ack_bit;
  logic poll_start;
  logic poll_lvl;
  logic poll_ok;
  logic poll_fail;
  logic unused_stat_hi;

  assign ack_bit        = phy_stat[BIT_ACK];
  assign unused_stat_hi = ^phy_stat[CTRL_W-1:BIT_ACK+1];

  phy_seq #(
    .CTRL_W (CTRL_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .ack_in      (ack_bit),
    .stat_data   (phy_stat[DATA_W-1:0]),
    .poll_ok     (poll_ok),
    .poll_fail   (poll_fail),
    .poll_start  (poll_start),
    .poll_lvl    (poll_lvl),
    .ready       (ready),
    .rdata       (rdata),
    .done        (done),
    .timeout_err (timeout_err),
    .ctrl        (phy_ctrl)
  );

  phy_ack_poller #(
    .SAMPLE_DIV (SAMPLE_DIV),
    .MAX_POLLS  (MAX_POLLS)
  ) u_poll (
    .clk        (clk),
    .rst        (rst),
    .start      (poll_start),
    .expect_lvl (poll_lvl),
    .ack_in     (ack_bit),
    .poll_ok    (poll_ok),
    .poll_fail  (poll_fail)
  );
endmodule

// File: tb/sim_phy_ctl_master.sv
`timescale 1ns/1ps
module sim_phy_ctl_master;
  localparam int DIV   = 4;
  localparam int POLLS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_addr  = '0;
  logic [15:0] cmd_wdata = '0;
  logic        ready, done, timeout_err;
  logic [15:0] rdata;
  logic [31:0] phy_ctrl;
  logic [31:0] phy_stat;

  always #5 clk = ~clk;

  phy_ctl_master #(.SAMPLE_DIV(DIV), .MAX_POLLS(POLLS)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .ready(ready),
    .rdata(rdata), .done(done), .timeout_err(timeout_err),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  // ---------------- PHY responder model ----------------
  int          ack_mode  = 0;   // 0 normal, 1 never acks, 2 ack stuck high
  int          ack_delay = 2;
  int          strobe_cnt;
  logic [31:0] prev_ctrl;
  logic [15:0] m_addr, m_data;
  logic [15:0] m_regs [16];
  logic        strobe_any, m_ack;

  assign strobe_any = |phy_ctrl[19:16];
  assign m_ack = (ack_mode == 2) ? 1'b1 :
                 (ack_mode == 1) ? 1'b0 : (strobe_any && strobe_cnt >= ack_delay);
  assign phy_stat = {15'd0, m_ack, m_regs[m_addr[3:0]]};

  always @(posedge clk) begin
    if (rst) begin
      strobe_cnt <= 0;
      prev_ctrl  <= '0;
      m_addr     <= '0;
      m_data     <= '0;
      for (int i = 0; i < 16; i++) m_regs[i] <= '0;
    end else begin
      strobe_cnt <= strobe_any ? strobe_cnt + 1 : 0;
      prev_ctrl  <= phy_ctrl;
      if (phy_ctrl[16] && !prev_ctrl[16]) m_addr <= phy_ctrl[15:0];
      if (phy_ctrl[17] && !prev_ctrl[17]) m_data <= phy_ctrl[15:0];
      if (phy_ctrl[18] && !prev_ctrl[18]) m_regs[m_addr[3:0]] <= m_data;
    end
  end

  // ---------------- control word log ----------------
  logic [31:0] log_q [64];
  int          log_n;
  logic [31:0] log_last;
  logic [31:0] exp_q [64];
  int          exp_n;
  logic [31:0] exp_last;

  always @(negedge clk) begin
    if (phy_ctrl != log_last) begin
      if (log_n < 64) log_q[log_n] = phy_ctrl;
      log_n++;
      log_last = phy_ctrl;
    end
  end

  task automatic exp_push(input logic [31:0] v);
    if (v != exp_last) begin
      exp_q[exp_n] = v;
      exp_n++;
      exp_last = v;
    end
  endtask

  task automatic build_expected(input logic wr, input logic [15:0] a, input logic [15:0] d);
    exp_n = 0; exp_last = 32'd0;
    exp_push({16'd0, a});
    exp_push({16'd1, a});
    exp_push({16'd0, a});
    if (wr) begin
      exp_push({16'd0, d});
      exp_push({16'd2, d});
      exp_push({16'd0, d});
      exp_push(32'h0004_0000);
      exp_push({16'd0, d});
      exp_push(32'd0);
    end else begin
      exp_push(32'h0008_0000);
      exp_push(32'd0);
    end
  endtask

  // ---------------- scoreboard ----------------
  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  task automatic check(input string req, input logic ok, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  logic        r_done, r_err, r_pulse_ok;
  logic [15:0] r_data;
  int          r_cycles;

  // Issue one command and wait for its end; also records pulse width.
  task automatic run_cmd(input logic wr, input logic [15:0] a, input logic [15:0] d);
    log_n = 0; log_last = phy_ctrl;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_cycles = 1; r_done = 0; r_err = 0;
    while (!done && !timeout_err && r_cycles < 3000) begin
      @(negedge clk);
      r_cycles++;
    end
    r_done = done; r_err = timeout_err; r_data = rdata;
    @(negedge clk);
    r_pulse_ok = !done && !timeout_err && ready;
  endtask

  // ---------------- stimulus table ----------------
  typedef struct packed { logic wr; logic [15:0] a; logic [15:0] d; } vec_t;
  localparam vec_t VEC [10] = '{
    '{1'b1, 16'h1005, 16'hA5C3},
    '{1'b1, 16'h100D, 16'h0001},
    '{1'b0, 16'h1005, 16'h0000},
    '{1'b0, 16'h100D, 16'h0000},
    '{1'b1, 16'h2223, 16'hFFFF},
    '{1'b1, 16'h0302, 16'h0302},
    '{1'b0, 16'h2223, 16'h0000},
    '{1'b0, 16'h0302, 16'h0000},
    '{1'b0, 16'h4447, 16'h0000},
    '{1'b1, 16'h1005, 16'h5A3C}
  };

  logic [15:0] shadow [16];

  task automatic compare_log(input string req);
    logic same;
    same = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < 64; i++) if (log_q[i] != exp_q[i]) same = 1'b0;
    check(req, same, "control word sequence length", log_n, exp_n);
  endtask

  initial begin
    log_n = 0; log_last = '0; exp_n = 0; exp_last = '0;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", ready === 1'b1, "ready in reset", ready, 1);
    check("R1", phy_ctrl === 32'd0 && done === 1'b0 && timeout_err === 1'b0,
          "outputs in reset", phy_ctrl, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", ready === 1'b1 && phy_ctrl === 32'd0, "idle after reset", phy_ctrl, 0);

    // Table walk: R2, R3, R4, R5, R8
    for (int k = 0; k < 10; k++) begin
      ack_delay = 1 + (k % 4);
      run_cmd(VEC[k].wr, VEC[k].a, VEC[k].d);
      build_expected(VEC[k].wr, VEC[k].a, VEC[k].d);
      compare_log(VEC[k].wr ? "R5" : "R4");
      check("R8", r_done && !r_err, "done without error", {r_done, r_err}, 2);
      check("R8", r_pulse_ok, "single-cycle end pulse and ready", r_pulse_ok, 1);
      if (VEC[k].wr) shadow[VEC[k].a[3:0]] = VEC[k].d;
      else check("R4", r_data == shadow[VEC[k].a[3:0]], "read data", r_data, shadow[VEC[k].a[3:0]]);
    end

    // R3: address bits 15:0 and capture-address bit 16 seen in the log
    ack_delay = 2;
    run_cmd(1'b0, 16'h8001, 16'h0);
    check("R3", log_q[1] == 32'h0001_8001, "address capture word", log_q[1], 32'h0001_8001);
    check("R2", log_q[3] == 32'h0008_0000, "read strobe at bit 19", log_q[3], 32'h0008_0000);

    // R6: acknowledge late but inside the window succeeds
    ack_delay = (POLLS - 2) * DIV;
    run_cmd(1'b1, 16'h3009, 16'h1234);
    shadow[9] = 16'h1234;
    check("R6", r_done && !r_err, "slow ack inside window", {r_done, r_err}, 2);
    ack_delay = 2;
    run_cmd(1'b0, 16'h3009, 16'h0);
    check("R6", r_data == 16'h1234, "read after slow write", r_data, 16'h1234);

    // R6: acknowledge beyond the window times out
    ack_delay = (POLLS + 3) * DIV;
    run_cmd(1'b0, 16'h3009, 16'h0);
    check("R6", r_err && !r_done, "late ack gives timeout", {r_done, r_err}, 1);
    check("R6", phy_ctrl == 32'd0 && ready, "control cleared after timeout", phy_ctrl, 0);

    // R6: PHY never acknowledges: exact timeout latency
    ack_mode = 1;
    run_cmd(1'b1, 16'h500A, 16'h7777);
    check("R6", r_err && !r_done, "no ack gives timeout", {r_done, r_err}, 1);
    check("R6", r_cycles >= 3 + (POLLS - 1) * DIV && r_cycles <= 7 + (POLLS - 1) * DIV,
          "timeout latency", r_cycles, 5 + (POLLS - 1) * DIV);
    check("R8", r_pulse_ok, "error pulse one cycle", r_pulse_ok, 1);

    // R6: acknowledge stuck high, release wait expires
    ack_mode = 2;
    run_cmd(1'b0, 16'h500A, 16'h0);
    check("R6", r_err, "stuck-high ack gives timeout", r_err, 1);
    ack_mode = 0; ack_delay = 2;
    run_cmd(1'b0, 16'h500A, 16'h0);
    check("R6", r_data == shadow[10], "aborted write left register", r_data, shadow[10]);

    // R7: command while busy is ignored
    ack_delay = 6;
    log_n = 0; log_last = phy_ctrl;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h600B; cmd_wdata = 16'hBEEF;
    @(negedge clk);
    cmd_addr = 16'h700C; cmd_wdata = 16'hDEAD;
    repeat (5) @(negedge clk);
    cmd_valid = 1'b0;
    r_cycles = 0;
    while (!done && r_cycles < 3000) begin @(negedge clk); r_cycles++; end
    @(negedge clk);
    build_expected(1'b1, 16'h600B, 16'hBEEF);
    compare_log("R7");
    check("R7", ready && phy_ctrl == 32'd0, "idle after busy request", phy_ctrl, 0);
    shadow[11] = 16'hBEEF;
    ack_delay = 2;
    run_cmd(1'b0, 16'h700C, 16'h0);
    check("R7", r_data == 16'h0000, "ignored command wrote nothing", r_data, 0);
    run_cmd(1'b0, 16'h600B, 16'h0);
    check("R7", r_data == 16'hBEEF, "first command completed", r_data, 16'hBEEF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule